// File: doc/BRIEF.md
# Security-Gated Coherency Event Counter Unit

This block is a compact performance monitor for a cache-coherent interconnect. Each clock it takes a small number of event lanes. Each lane carries a valid bit, a 4-bit coherency class code and a secure/non-secure tag. The events are counted by seven programmable event counters, and a free-running cycle counter sits beside them. All counters are 32 bits wide. Four debug-authentication inputs decide whether counting may happen at all, and whether secure-tagged events count. One of them enables invasive debug, one enables non-invasive debug, and the other two are the secure versions of these.

Software reaches the unit through a plain single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the addressed register. Through this port software picks the class each event counter watches, sets the global and per-counter enables, loads or reads counter values, and clears overflow flags. A counter that wraps past all-ones sets a sticky flag. The eight flags drive the `ovf_flags` output directly.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset, every counter, selector, control bit and overflow flag reads zero, and `ovf_flags` is zero.
- R2: The cycle counter increases by exactly one on each clock where control bit 0 (global enable) is set and counting is permitted for non-secure state.
- R3: Event counter n (0..6) counts only when control bit 0 and control bit n+1 are both set. It then increases by the number of lanes in that cycle that have valid high, a class equal to its selector, and a permitted security state.
- R4: The defined class codes are 3 (single-use read), 4 (reads that may allocate: clean, shared, not-shared-dirty, unique), 5 (make-unique and clean-unique), 6 (clean-invalid, clean-shared, make-invalid), 7 (distributed virtual memory message from an upstream port) and 9 (read data supplied by a snoop). A counter whose selector holds any other value (0, 1, 2, 8, 10..15) never counts.
- R5: Non-secure events, and the cycle counter, are permitted when the invasive enable or the non-invasive enable is high. With both low, no counter advances.
- R6: Secure events are permitted only when the secure invasive enable and the invasive enable are both high, or when the secure non-invasive enable and the non-invasive enable are both high.
- R7: A counter that passes all-ones wraps modulo 2^32 and sets its flag. Bit 0 of `ovf_flags` belongs to the cycle counter and bit n+1 to event counter n.
- R8: A flag stays set until software writes a one to that bit at address 1, and writing zero bits leaves the flag unchanged. If a wrap and a clear of the same bit happen in the same cycle, the flag is set.
- R9: Register map by word address: 0 holds the control bits [7:0], 1 the flags, 2 the cycle counter, 8+n the event counter n and 16+n the selector n (4 bits). A software write to a counter loads that value, overrides any increment in the same cycle, and does not set a flag.
- R10: Reads of any unmapped address (3..7, 15, 23..31) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_valid | input | 2 | Per-lane event valid |
| ev_class | input | 8 | Per-lane 4-bit class code, lane l in bits [4l+3:4l] |
| ev_secure | input | 2 | Per-lane security tag, 1 = secure |
| dbg_inv_en | input | 1 | Invasive debug enable |
| dbg_noninv_en | input | 1 | Non-invasive debug enable |
| dbg_sec_inv_en | input | 1 | Secure invasive debug enable |
| dbg_sec_noninv_en | input | 1 | Secure non-invasive debug enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ovf_flags | output | 8 | Sticky overflow flags |

## Verification
The hardest situation to reach from the ports is a wrap. Counting up from zero would take billions of cycles, so the stimulus first loads a counter with all-ones or all-ones minus one through the register port. It then releases one or two counted events, or a couple of enabled cycles. The collision cases are reached by driving a write and an event pulse in the same cycle. In one, a flag clear meets the wrap it was set by. In the other, a counter load meets an increment. A behavioural model tracks every register, and a random phase then mixes near-wrap loads, selector changes and debug-enable toggles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    EVC_NONE      = 4'd0,
    EVC_RD_ONCE   = 4'd3,
    EVC_RD_ALLOC  = 4'd4,
    EVC_MK_UNIQUE = 4'd5,
    EVC_CLEAN_INV = 4'd6,
    EVC_DVM       = 4'd7,
    EVC_SNP_DATA  = 4'd9
  } ev_class_e;

  // True for the class codes that name a countable coherency event.
  function automatic logic cls_defined(input logic [CLS_W-1:0] c);
    case (c)
      EVC_RD_ONCE, EVC_RD_ALLOC, EVC_MK_UNIQUE,
      EVC_CLEAN_INV, EVC_DVM, EVC_SNP_DATA: return 1'b1;
      default:                              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmu_auth_gate.sv
module pmu_auth_gate (
  input  logic dbg_inv_en,
  input  logic dbg_noninv_en,
  input  logic dbg_sec_inv_en,
  input  logic dbg_sec_noninv_en,
  output logic permit_ns,
  output logic permit_s
);

  always_comb begin
    permit_ns = dbg_inv_en | dbg_noninv_en;
    permit_s  = (dbg_inv_en & dbg_sec_inv_en) | (dbg_noninv_en & dbg_sec_noninv_en);
  end

endmodule

// File: rtl/pmu_lane_filter.sv
module pmu_lane_filter
  import pmu_pkg::*;
#(
  parameter int LANES = 2,
  parameter int INC_W = 2
) (
  input  logic [LANES-1:0]       ev_valid,
  input  logic [LANES*CLS_W-1:0] ev_class,
  input  logic [LANES-1:0]       ev_secure,
  input  logic                   permit_ns,
  input  logic                   permit_s,
  input  logic [CLS_W-1:0]       sel,
  output logic [INC_W-1:0]       hits
);

  logic sel_ok;

  always_comb begin
    sel_ok = cls_defined(sel);
    hits   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (ev_valid[l] && sel_ok && (ev_class[l*CLS_W +: CLS_W] == sel) &&
          (ev_secure[l] ? permit_s : permit_ns)) begin
        hits = hits + INC_W'(1);
      end
    end
  end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W  = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          inc_en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  val,
  output logic          wrap
);

  logic [W-1:0] val_q, val_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, val_q} + {{(W+1-IW){1'b0}}, inc};
    val_d = val_q;
    wrap  = 1'b0;
    if (load) begin
      val_d = load_val;
    end else if (inc_en) begin
      val_d = sum[W-1:0];
      wrap  = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val = val_q;

endmodule

// File: rtl/perf_event_monitor.sv
module perf_event_monitor
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 7,
  parameter int LANES    = 2,
  parameter int CNT_W    = 32,
  parameter int ADDR_W   = 5,
  parameter int EVT_BASE = 8,
  parameter int SEL_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       ev_valid,
  input  logic [LANES*CLS_W-1:0] ev_class,
  input  logic [LANES-1:0]       ev_secure,
  input  logic                   dbg_inv_en,
  input  logic                   dbg_noninv_en,
  input  logic                   dbg_sec_inv_en,
  input  logic                   dbg_sec_noninv_en,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [CNT_W-1:0]       reg_wdata,
  output logic [CNT_W-1:0]       reg_rdata,
  output logic [NUM_EVT:0]       ovf_flags
);

  localparam int NFLAG     = NUM_EVT + 1;
  localparam int INC_W     = $clog2(LANES + 1);
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_FLAG = 1;
  localparam int ADDR_CYC  = 2;

  logic permit_ns, permit_s;

  pmu_auth_gate u_gate (
    .dbg_inv_en        (dbg_inv_en),
    .dbg_noninv_en     (dbg_noninv_en),
    .dbg_sec_inv_en    (dbg_sec_inv_en),
    .dbg_sec_noninv_en (dbg_sec_noninv_en),
    .permit_ns         (permit_ns),
    .permit_s          (permit_s)
  );

  // Write decode
  logic               wr_ctrl, wr_flag, wr_cyc;
  logic [NUM_EVT-1:0] wr_evt, wr_sel;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
    wr_flag = reg_we && (reg_addr == ADDR_W'(ADDR_FLAG));
    wr_cyc  = reg_we && (reg_addr == ADDR_W'(ADDR_CYC));
    for (int n = 0; n < NUM_EVT; n++) begin
      wr_evt[n] = reg_we && (reg_addr == ADDR_W'(EVT_BASE + n));
      wr_sel[n] = reg_we && (reg_addr == ADDR_W'(SEL_BASE + n));
    end
  end

  // Control, selector and flag state
  logic [NFLAG-1:0] ctrl_q, ctrl_d;
  logic [NFLAG-1:0] flags_q, flags_d, flag_clr, wrap_vec;
  logic [CLS_W-1:0] sel_q [NUM_EVT];
  logic [CLS_W-1:0] sel_d [NUM_EVT];

  always_comb begin
    ctrl_d   = wr_ctrl ? reg_wdata[NFLAG-1:0] : ctrl_q;
    flag_clr = wr_flag ? reg_wdata[NFLAG-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | wrap_vec;
    for (int n = 0; n < NUM_EVT; n++) begin
      sel_d[n] = wr_sel[n] ? reg_wdata[CLS_W-1:0] : sel_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      for (int n = 0; n < NUM_EVT; n++) sel_q[n] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
      for (int n = 0; n < NUM_EVT; n++) sel_q[n] <= sel_d[n];
    end
  end

  // Cycle counter
  logic [CNT_W-1:0] cyc_val;
  logic             cyc_wrap;

  pmu_counter #(.W(CNT_W), .IW(1)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_cyc),
    .load_val (reg_wdata),
    .inc_en   (ctrl_q[0] & permit_ns),
    .inc      (1'b1),
    .val      (cyc_val),
    .wrap     (cyc_wrap)
  );

  // Event counters
  logic [CNT_W-1:0]   evt_val [NUM_EVT];
  logic [NUM_EVT-1:0] evt_wrap;

  for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
    logic [INC_W-1:0] hits;

    pmu_lane_filter #(.LANES(LANES), .INC_W(INC_W)) u_filt (
      .ev_valid  (ev_valid),
      .ev_class  (ev_class),
      .ev_secure (ev_secure),
      .permit_ns (permit_ns),
      .permit_s  (permit_s),
      .sel       (sel_q[n]),
      .hits      (hits)
    );

    pmu_counter #(.W(CNT_W), .IW(INC_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_evt[n]),
      .load_val (reg_wdata),
      .inc_en   (ctrl_q[0] & ctrl_q[n+1]),
      .inc      (hits),
      .val      (evt_val[n]),
      .wrap     (evt_wrap[n])
    );
  end

  assign wrap_vec = {evt_wrap, cyc_wrap};

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) reg_rdata = CNT_W'(ctrl_q);
    if (reg_addr == ADDR_W'(ADDR_FLAG)) reg_rdata = CNT_W'(flags_q);
    if (reg_addr == ADDR_W'(ADDR_CYC))  reg_rdata = cyc_val;
    for (int n = 0; n < NUM_EVT; n++) begin
      if (reg_addr == ADDR_W'(EVT_BASE + n)) reg_rdata = evt_val[n];
      if (reg_addr == ADDR_W'(SEL_BASE + n)) reg_rdata = CNT_W'(sel_q[n]);
    end
  end

  assign ovf_flags = flags_q;

endmodule

// File: rtl/pmu_event_monitor_chk.sv
module pmu_event_monitor_chk
  import pmu_pkg::*;
#(
  parameter int NFLAG     = 8,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 5,
  parameter int FLAG_ADDR = 1,
  parameter int CYC_ADDR  = 2,
  parameter int EVT0_ADDR = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NFLAG-1:0]  wdata_lo,
  input logic              dbg_inv_en,
  input logic              dbg_noninv_en,
  input logic              glob_en,
  input logic [CNT_W-1:0]  cyc_val,
  input logic [CNT_W-1:0]  evt0_val,
  input logic [CLS_W-1:0]  sel0,
  input logic [NFLAG-1:0]  ovf_flags
);

  logic             wr_cyc, wr_evt0, run;
  logic [NFLAG-1:0] clr, keep;

  assign wr_cyc  = reg_we && (reg_addr == ADDR_W'(CYC_ADDR));
  assign wr_evt0 = reg_we && (reg_addr == ADDR_W'(EVT0_ADDR));
  assign clr     = (reg_we && (reg_addr == ADDR_W'(FLAG_ADDR))) ? wdata_lo : '0;
  assign keep    = ovf_flags & ~clr;
  assign run     = glob_en && (dbg_inv_en || dbg_noninv_en) && !wr_cyc;

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cyc_val != '1)) |=> (cyc_val == $past(cyc_val) + 1'b1)); // R2

  AST_NO_PERMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_inv_en && !dbg_noninv_en && !wr_cyc) |=> $stable(cyc_val)); // R5

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cyc_val == '1)) |=> (ovf_flags[0] && (cyc_val == '0))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|keep) |=> ((ovf_flags & $past(keep)) == $past(keep))); // R8

  AST_UNUSED_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel0 == '0) && !wr_evt0) |=> $stable(evt0_val)); // R4

endmodule

bind perf_event_monitor pmu_event_monitor_chk #(
  .NFLAG     (NUM_EVT + 1),
  .CNT_W     (CNT_W),
  .ADDR_W    (ADDR_W),
  .FLAG_ADDR (1),
  .CYC_ADDR  (2),
  .EVT0_ADDR (EVT_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .wdata_lo      (reg_wdata[NUM_EVT:0]),
  .dbg_inv_en    (dbg_inv_en),
  .dbg_noninv_en (dbg_noninv_en),
  .glob_en       (ctrl_q[0]),
  .cyc_val       (cyc_val),
  .evt0_val      (evt_val[0]),
  .sel0          (sel_q[0]),
  .ovf_flags     (ovf_flags)
);

// File: tb/perf_event_monitor_test.sv
`timescale 1ns/1ps
module perf_event_monitor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ev_valid = '0;
  logic [7:0]  ev_class = '0;
  logic [1:0]  ev_secure = '0;
  logic        dbg_inv_en = 1'b0, dbg_noninv_en = 1'b0;
  logic        dbg_sec_inv_en = 1'b0, dbg_sec_noninv_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  ovf_flags;

  int checks = 0;
  int failures = 0;
  int wd_cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  perf_event_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_class(ev_class), .ev_secure(ev_secure),
    .dbg_inv_en(dbg_inv_en), .dbg_noninv_en(dbg_noninv_en),
    .dbg_sec_inv_en(dbg_sec_inv_en), .dbg_sec_noninv_en(dbg_sec_noninv_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_flags(ovf_flags)
  );

  // ---------------- behavioural reference model ----------------
  longint m_cyc;
  longint m_cnt [7];
  int     m_sel [7];
  int     m_ctrl;
  int     m_flags;
  localparam longint WRAP = 64'h1_0000_0000;

  function automatic bit code_ok(input int c);
    return (c == 3) || (c == 4) || (c == 5) || (c == 6) || (c == 7) || (c == 9);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_ctrl = 0; m_flags = 0;
      for (int n = 0; n < 7; n++) begin m_cnt[n] = 0; m_sel[n] = 0; end
    end else begin
      bit pns, ps;
      int set_bits;
      int a;
      pns = dbg_inv_en || dbg_noninv_en;
      ps  = (dbg_inv_en && dbg_sec_inv_en) || (dbg_noninv_en && dbg_sec_noninv_en);
      set_bits = 0;
      a = reg_we ? int'(reg_addr) : -1;
      if (a == 2) m_cyc = longint'(reg_wdata);
      else if ((m_ctrl & 1) && pns) begin
        m_cyc++;
        if (m_cyc >= WRAP) begin m_cyc -= WRAP; set_bits |= 1; end
      end
      for (int n = 0; n < 7; n++) begin
        int hits;
        hits = 0;
        for (int l = 0; l < 2; l++) begin
          if (ev_valid[l] && code_ok(m_sel[n]) && (int'(ev_class[l*4 +: 4]) == m_sel[n]) &&
              (ev_secure[l] ? ps : pns)) hits++;
        end
        if (a == 8 + n) m_cnt[n] = longint'(reg_wdata);
        else if ((m_ctrl & 1) && ((m_ctrl >> (n + 1)) & 1)) begin
          m_cnt[n] += hits;
          if (m_cnt[n] >= WRAP) begin m_cnt[n] -= WRAP; set_bits |= (1 << (n + 1)); end
        end
      end
      m_flags = (m_flags & ~((a == 1) ? int'(reg_wdata[7:0]) : 0)) | set_bits;
      if (a == 0) m_ctrl = int'(reg_wdata[7:0]);
      for (int n = 0; n < 7; n++) if (a == 16 + n) m_sel[n] = int'(reg_wdata[3:0]);
    end
  end

  function automatic longint model_read(input int a);
    if (a == 0) return m_ctrl;
    if (a == 1) return m_flags;
    if (a == 2) return m_cyc;
    if (a >= 8 && a < 15) return m_cnt[a-8];
    if (a >= 16 && a < 23) return m_sel[a-16];
    return 0;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 1) return "R8";
    if (a == 2) return "R2";
    if (a >= 8 && a < 15) return "R3";
    if (a == 0 || (a >= 16 && a < 23)) return "R9";
    return "R10";
  endfunction

  // Per-clock comparison, a quarter period after the edge.
  always @(posedge clk) begin
    #5;
    if (!finished) begin
      checks++;
      if (reg_rdata !== 32'(model_read(int'(reg_addr)))) begin
        failures++;
        $display("FAIL %s: model compare addr %0d actual %h expected %h",
                 tag_of(int'(reg_addr)), reg_addr, reg_rdata, 32'(model_read(int'(reg_addr))));
      end
      checks++;
      if (ovf_flags !== 8'(m_flags)) begin
        failures++;
        $display("FAIL R7: model compare flags actual %h expected %h", ovf_flags, 8'(m_flags));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic finish_run();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 20000 && !finished) begin
      failures++;
      $display("FAIL R1: watchdog actual %0d cycles expected fewer than 20000", wd_cycles);
      finish_run();
    end
  end

  task automatic check_rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 5'(a);
    #5;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s: read addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic check_flags(input logic [7:0] exp, input string tag);
    @(negedge clk);
    #5;
    checks++;
    if (ovf_flags !== exp) begin
      failures++;
      $display("FAIL %s: ovf_flags actual %h expected %h", tag, ovf_flags, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_dbg(input bit i, input bit ni, input bit si, input bit sni);
    @(negedge clk);
    dbg_inv_en = i; dbg_noninv_en = ni; dbg_sec_inv_en = si; dbg_sec_noninv_en = sni;
  endtask

  task automatic pulse(input int c0, input bit s0, input int c1, input bit s1);
    @(negedge clk);
    ev_valid = 2'b11; ev_class = {4'(c1), 4'(c0)}; ev_secure = {s1, s0};
    @(negedge clk);
    ev_valid = 2'b00;
  endtask

  // ---------------- directed and random stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_rd(0, 32'h0, "R1");
    check_rd(2, 32'h0, "R1");
    check_rd(8, 32'h0, "R1");
    check_rd(16, 32'h0, "R1");
    check_flags(8'h00, "R1");

    // selectors: 3,4,0,9,8,7,5 ; enable all
    wr(16, 3); wr(17, 4); wr(18, 0); wr(19, 9); wr(20, 8); wr(21, 7); wr(22, 5);
    wr(0, 32'hFF);

    // R2: exactly six permitted cycles
    @(negedge clk); dbg_inv_en = 1'b1;
    repeat (6) @(negedge clk);
    dbg_inv_en = 1'b0;
    check_rd(2, 32'd6, "R2");
    repeat (4) @(negedge clk);
    check_rd(2, 32'd6, "R5");

    // Events under several authentication settings
    set_dbg(1, 0, 0, 0);
    pulse(3, 0, 3, 0);          // R3: two hits on counter 0
    pulse(4, 1, 9, 0);          // R6: secure blocked; counter 3 +1
    pulse(0, 0, 8, 0);          // R4: unused codes
    set_dbg(1, 0, 1, 0);
    pulse(4, 1, 1, 0);          // R6: secure allowed via invasive pair
    set_dbg(0, 0, 1, 0);
    pulse(4, 1, 4, 1);          // R6: secure invasive alone is not enough
    set_dbg(0, 1, 0, 0);
    pulse(7, 1, 7, 0);          // R5: non-invasive counts non-secure only
    set_dbg(0, 1, 0, 1);
    pulse(5, 1, 2, 0);          // R6: secure non-invasive pair
    set_dbg(0, 0, 0, 0);
    check_rd(8,  32'd2, "R3");
    check_rd(9,  32'd1, "R6");
    check_rd(10, 32'd0, "R4");
    check_rd(11, 32'd1, "R3");
    check_rd(12, 32'd0, "R4");
    check_rd(13, 32'd1, "R5");
    check_rd(14, 32'd1, "R6");

    // R3: per-counter enable off for counter 0
    wr(0, 32'hFD);
    set_dbg(1, 0, 0, 0);
    pulse(3, 0, 3, 0);
    set_dbg(0, 0, 0, 0);
    check_rd(8, 32'd2, "R3");
    wr(0, 32'hFF);

    // R7: event counter wrap by a two-lane increment
    wr(9, 32'hFFFF_FFFF);
    set_dbg(1, 0, 0, 0);
    pulse(4, 0, 4, 0);
    set_dbg(0, 0, 0, 0);
    check_rd(9, 32'd1, "R7");
    check_flags(8'h04, "R7");

    // R7: cycle counter wrap
    wr(2, 32'hFFFF_FFFE);
    @(negedge clk); dbg_inv_en = 1'b1;
    repeat (2) @(negedge clk);
    dbg_inv_en = 1'b0;
    check_rd(2, 32'd0, "R7");
    check_flags(8'h05, "R7");

    // R8: sticky, then write-one-to-clear of bit 0 only
    repeat (5) @(negedge clk);
    check_flags(8'h05, "R8");
    wr(1, 32'h0000_0002);
    check_flags(8'h05, "R8");
    wr(1, 32'h0000_0001);
    check_flags(8'h04, "R8");

    // R8: wrap and clear of the same bit in one cycle; set wins
    wr(8, 32'hFFFF_FFFF);
    @(negedge clk);
    dbg_inv_en = 1'b1;
    reg_we = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h2;
    ev_valid = 2'b01; ev_class = 8'h03; ev_secure = 2'b00;
    @(negedge clk);
    reg_we = 1'b0; ev_valid = 2'b00; dbg_inv_en = 1'b0;
    check_rd(8, 32'd0, "R7");
    check_flags(8'h06, "R8");

    // R9: load overrides a same-cycle increment, no flag
    @(negedge clk);
    dbg_inv_en = 1'b1;
    reg_we = 1'b1; reg_addr = 5'd11; reg_wdata = 32'd5;
    ev_valid = 2'b01; ev_class = 8'h09; ev_secure = 2'b00;
    @(negedge clk);
    reg_we = 1'b0; ev_valid = 2'b00; dbg_inv_en = 1'b0;
    check_rd(11, 32'd5, "R9");
    check_flags(8'h06, "R9");

    // R9 / R10: register readback and unmapped holes
    check_rd(16, 32'd3, "R9");
    check_rd(20, 32'd8, "R9");
    check_rd(0, 32'hFF, "R9");
    check_rd(3, 32'd0, "R10");
    check_rd(15, 32'd0, "R10");
    check_rd(31, 32'd0, "R10");
    wr(1, 32'hFF);
    check_flags(8'h00, "R8");

    // Random phase checked against the model every clock
    for (int i = 0; i < 3000; i++) begin
      int k;
      @(negedge clk);
      if ($urandom_range(0, 15) == 0) begin
        dbg_inv_en = 1'($urandom); dbg_noninv_en = 1'($urandom);
        dbg_sec_inv_en = 1'($urandom); dbg_sec_noninv_en = 1'($urandom);
      end
      ev_valid  = 2'($urandom);
      ev_class  = 8'($urandom);
      ev_secure = 2'($urandom);
      k = $urandom_range(0, 19);
      if (k < 7) reg_addr = 5'(8 + k);
      else if (k < 14) reg_addr = 5'(16 + k - 7);
      else if (k == 14) reg_addr = 5'd0;
      else if (k == 15) reg_addr = 5'd1;
      else if (k == 16) reg_addr = 5'd2;
      else if (k == 17) reg_addr = 5'd3;
      else if (k == 18) reg_addr = 5'd31;
      else reg_addr = 5'd15;
      reg_we = ($urandom_range(0, 7) == 0);
      if (reg_addr == 5'd0) reg_wdata = ($urandom_range(0, 3) == 0) ? 32'($urandom) : 32'hFF;
      else if (reg_addr >= 5'd16) reg_wdata = 32'($urandom_range(0, 15));
      else reg_wdata = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
    end
    @(negedge clk);
    reg_we = 1'b0; ev_valid = 2'b00;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule